// File: doc/BRIEF.md
# Rectangle Fill Colour-Expansion Engine

A register-programmed unit that paints axis-aligned rectangles of 8-bit pixels into a framebuffer whose rows are 2048 pixels apart. Software loads a destination corner, a 32-bit stipple pattern, two colours, a raster operation and a plane mask, then launches the fill by writing the rectangle size to a start alias of the size register. The engine walks the rectangle row by row in 32-pixel chunks. Each pattern bit picks the foreground or background colour for one pixel, or leaves that pixel alone when the background is transparent.

Each pixel goes through a read-modify-write on a simple request/acknowledge memory port. The old pixel is read, combined with the source colour through the raster op, merged under the plane mask, and written back. The right border is either clipped to the exact width or extended to a whole chunk, depending on a mode bit. When a fill finishes, the destination Y coordinate moves down by the rectangle height, so repeated launches stack vertically without reprogramming the corner.

Top module: `rect_fill_engine`

## Requirements
- R1: Register index (reg_addr) selects: 0 corner, 1 size (load only), 2 size with start, 3 pattern, 4 foreground, 5 background, 6 mode, 7 plane mask. Corner and size put X or width in bits 31:16 and Y or height in bits 15:0. A write to index 1 never starts a fill.
- R2: The pixel at column c and row r of the rectangle is accessed at address (Y+r)*2048 + X + c.
- R3: Pattern bit 31−(c mod 32) chooses the source for column c. A set bit selects the foreground (bits 7:0 of index 4), a clear bit the background (bits 7:0 of index 5). Every row uses the same pattern.
- R4: When mode bit 4 is set, pixels with a clear pattern bit are neither read nor written.
- R5: When mode bit 5 is set, only columns below the width are touched. When it is clear, every column up to the next multiple of 32 is filled.
- R6: With rop = mode bits 3:0, each result bit equals rop[3 − 2·s − d], where s is the source bit and d is the old bit (0x0 clear, 0x3 copy, 0xC inverted source, 0xF set, 0xA inverted destination).
- R7: Only bits that are set in the plane mask (bits 7:0 of index 7) may change in a written pixel.
- R8: When a fill completes, the stored corner Y grows by the fill height, so a launch without a corner write lands directly below.
- R9: A zero width or zero height makes no memory access and leaves busy low, but still adds the height to the corner Y.
- R10: Busy is low after reset. It is high from the cycle after a launch until the cycle after the last write is acknowledged. A start write while busy does not launch a new fill, and other register writes made while busy apply only to the next fill.
- R11: Each touched pixel gets one read and then one write to the same address, and each request is held unchanged until mem_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| busy | output | 1 | Fill in progress |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 22 | Pixel address |
| mem_wdata | output | 8 | Pixel write data |
| mem_rdata | input | 8 | Pixel read data |
| mem_ack | input | 1 | Request acknowledge |

## Verification
Fills are swept over widths on both sides of each chunk boundary (1, 5, 31, 32, 33, 40, 63, 64, 65 and 0) with clipping on and off, which separates exact-width clipping from whole-chunk fill. Four pattern shapes (all ones, none, only the two edge bits, and a mixed word) distinguish which bit drives which column and expose transparency. Eight raster ops and a partial plane mask are applied over a framebuffer preloaded with an address-dependent pattern, so every op and mask leaves a distinct result. Launches without a corner write, zero-size fills, and register writes made while a fill runs check the Y stacking and the latching of the fill settings.

// File: rtl/rect_fill_engine.sv
module rect_fill_engine #(
  parameter int PIX_W      = 8,
  parameter int PITCH_LOG2 = 11,
  parameter int ADDR_W     = 22,
  parameter int MASK_W     = 32,
  parameter int CRD_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [PIX_W-1:0]  mem_wdata,
  input  logic [PIX_W-1:0]  mem_rdata,
  input  logic              mem_ack
);
  localparam int CNT_W  = CRD_W + 1;
  localparam int CIDX_W = $clog2(MASK_W);
  localparam logic [2:0] A_DST = 3'd0, A_SIZE = 3'd1, A_GO = 3'd2, A_MASK = 3'd3,
                         A_FG = 3'd4, A_BG = 3'd5, A_MODE = 3'd6, A_PM = 3'd7;

  typedef enum logic [1:0] {IDLE, STEP, RD, WR} state_t;
  state_t state;

  logic [CRD_W-1:0]  dst_x, dst_y, sz_w, sz_h, x_l, y_l, w_l, h_l, row;
  logic [MASK_W-1:0] mask, mask_l;
  logic [PIX_W-1:0]  fg, bg, pm, fg_l, bg_l, pm_l, old_q;
  logic [5:0]        mode, mode_l;
  logic [CNT_W-1:0]  col, span;

  wire [CRD_W-1:0] wd_hi = reg_wdata[16 +: CRD_W];
  wire [CRD_W-1:0] wd_lo = reg_wdata[0 +: CRD_W];
  wire launch = reg_we && reg_addr == A_GO && state == IDLE;
  wire empty  = wd_hi == '0 || wd_lo == '0;

  assign span = mode_l[5] ? {1'b0, w_l}
                          : (({1'b0, w_l} + CNT_W'(MASK_W - 1)) & ~CNT_W'(MASK_W - 1));
  wire [CIDX_W-1:0] bit_idx = CIDX_W'(MASK_W - 1) - col[CIDX_W-1:0];
  wire mbit     = mask_l[bit_idx];
  wire wr_pix   = mbit || !mode_l[4];
  wire last_col = col == span - 1'b1;
  wire last_row = row == h_l - 1'b1;
  wire advance  = (state == STEP && !wr_pix) || (state == WR && mem_ack);

  wire [PIX_W-1:0] src = mbit ? fg_l : bg_l;
  wire [PIX_W-1:0] rop_out = ({PIX_W{mode_l[0]}} &  src &  old_q) |
                             ({PIX_W{mode_l[1]}} &  src & ~old_q) |
                             ({PIX_W{mode_l[2]}} & ~src &  old_q) |
                             ({PIX_W{mode_l[3]}} & ~src & ~old_q);

  wire [CRD_W-1:0] cur_y = y_l + row;
  assign mem_addr  = (ADDR_W'(cur_y) << PITCH_LOG2) + ADDR_W'(x_l) + ADDR_W'(col);
  assign mem_wdata = (rop_out & pm_l) | (old_q & ~pm_l);
  assign mem_req   = state == RD || state == WR;
  assign mem_we    = state == WR;
  assign busy      = state != IDLE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_x <= '0; dst_y <= '0; sz_w <= '0; sz_h <= '0; mask <= '0;
      fg <= '0; bg <= '0; pm <= '1; mode <= 6'h03;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          A_DST:         begin dst_x <= wd_hi; dst_y <= wd_lo; end
          A_SIZE, A_GO:  begin sz_w <= wd_hi; sz_h <= wd_lo; end
          A_MASK:        mask <= reg_wdata[MASK_W-1:0];
          A_FG:          fg   <= reg_wdata[PIX_W-1:0];
          A_BG:          bg   <= reg_wdata[PIX_W-1:0];
          A_MODE:        mode <= reg_wdata[5:0];
          default:       pm   <= reg_wdata[PIX_W-1:0];
        endcase
      end
      if (launch && empty) dst_y <= dst_y + wd_lo;
      if (advance && last_col && last_row) dst_y <= dst_y + h_l;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= IDLE; col <= '0; row <= '0; old_q <= '0;
      x_l <= '0; y_l <= '0; w_l <= '0; h_l <= '0; mask_l <= '0;
      fg_l <= '0; bg_l <= '0; pm_l <= '0; mode_l <= '0;
    end else begin
      case (state)
        IDLE: if (launch && !empty) begin
          state <= STEP; col <= '0; row <= '0;
          x_l <= dst_x; y_l <= dst_y; w_l <= wd_hi; h_l <= wd_lo;
          mask_l <= mask; fg_l <= fg; bg_l <= bg; pm_l <= pm; mode_l <= mode;
        end
        STEP: if (wr_pix) state <= RD;
        RD:   if (mem_ack) begin old_q <= mem_rdata; state <= WR; end
        default: ;
      endcase
      if (advance) begin
        if (last_col) begin
          col <= '0;
          if (last_row) state <= IDLE;
          else begin row <= row + 1'b1; state <= STEP; end
        end else begin
          col <= col + 1'b1; state <= STEP;
        end
      end
    end
  end

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));
  // R11
  rmw_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we && mem_ack |=> mem_req && mem_we && $stable(mem_addr));
  // R7
  pmask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && $past(mem_req && !mem_we) |->
      ((mem_wdata ^ $past(mem_rdata)) & ~pm_l) == '0);
  // R5
  clip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mode_l[5] |-> col < {1'b0, w_l});
  // R10
  hold_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(w_l) && $stable(mask_l) && $stable(fg_l));
  // R8
  yadv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> dst_y == $past(dst_y) + $past(h_l));
  // R1
  no_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_addr == A_SIZE && !busy |=> !busy);
endmodule

// File: tb/rect_fill_engine_tb.sv
module rect_fill_engine_tb;
  logic clk = 0, rst_n = 0, reg_we = 0, mem_ack = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [7:0] mem_rdata = 0;
  logic busy, mem_req, mem_we;
  logic [21:0] mem_addr;
  logic [7:0] mem_wdata;
  int compared = 0, mismatched = 0, req_cnt = 0;
  logic [7:0] mem [int];
  logic [7:0] expm [int];
  int cur_x = 0, cur_y = 0;

  always #10 clk = ~clk;

  rect_fill_engine u_dut (.clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .busy,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_rdata, .mem_ack);

  function automatic logic [7:0] bgpat(int a);
    return 8'(a) ^ 8'h5A ^ 8'(a >> 8);
  endfunction

  always @(negedge clk) begin
    if (mem_req && !mem_ack) begin
      if (mem_we) mem[int'(mem_addr)] = mem_wdata;
      else mem_rdata = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : bgpat(int'(mem_addr));
      mem_ack = 1;
    end else mem_ack = 0;
  end
  always @(posedge clk) if (mem_req && mem_ack) req_cnt++;

  task automatic check(bit ok, string tag, int act, int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wreg(logic [2:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 20000) begin @(negedge clk); n++; end
    if (busy) check(0, "R10 watchdog on busy", 1, 0);
  endtask

  function automatic logic [7:0] ropf(logic [3:0] r, logic [7:0] s, logic [7:0] d);
    logic [7:0] o;
    for (int k = 0; k < 8; k++) o[k] = r[3 - 2*int'(s[k]) - int'(d[k])];
    return o;
  endfunction

  function automatic int spanf(int w, bit clip);
    return clip ? w : ((w + 31) / 32) * 32;
  endfunction

  task automatic model(int x, int y, int w, int h, logic [31:0] m, logic [7:0] fg,
                       logic [7:0] bg, logic [5:0] mode, logic [7:0] pm);
    int sp = spanf(w, mode[5]);
    if (w == 0 || h == 0) return;
    for (int r = 0; r < h; r++)
      for (int c = 0; c < sp; c++) begin
        int a = (y + r) * 2048 + x + c;
        logic b = m[31 - (c % 32)];
        logic [7:0] old, s;
        if (!b && mode[4]) continue;
        old = expm.exists(a) ? expm[a] : bgpat(a);
        s = b ? fg : bg;
        expm[a] = (ropf(mode[3:0], s, old) & pm) | (old & ~pm);
      end
  endtask

  task automatic compare(int x, int y, int w, int h, bit clip, string tag);
    int sp = spanf(w, clip);
    for (int r = y - 1; r <= y + h; r++)
      for (int c = x - 2; c <= x + sp + 1; c++) begin
        int a = r * 2048 + c;
        logic [7:0] e = expm.exists(a) ? expm[a] : bgpat(a);
        logic [7:0] g = mem.exists(a) ? mem[a] : bgpat(a);
        check(g == e, tag, g, e);
      end
  endtask

  task automatic fill(bit setdst, int x, int y, int w, int h, logic [31:0] m,
                      logic [7:0] fg, logic [7:0] bg, logic [5:0] mode, logic [7:0] pm);
    int rc;
    if (setdst) begin cur_x = x; cur_y = y; wreg(3'd0, {16'(x), 16'(y)}); end
    wreg(3'd3, m); wreg(3'd4, 32'(fg)); wreg(3'd5, 32'(bg));
    wreg(3'd6, 32'(mode)); wreg(3'd7, 32'(pm));
    rc = req_cnt;
    wreg(3'd2, {16'(w), 16'(h)});
    if (w == 0 || h == 0) begin
      check(busy == 0, "R9 busy on empty fill", busy, 0);
      repeat (3) @(negedge clk);
      check(req_cnt == rc, "R9 no access on empty fill", req_cnt - rc, 0);
    end else check(busy == 1, "R10 busy after launch", busy, 1);
    wait_idle();
    model(cur_x, cur_y, w, h, m, fg, bg, mode, pm);
    compare(cur_x, cur_y, w, h, mode[5], "R2 R3 R4 R5 R6 R7 R8 pixel");
    cur_y += h;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "R10 global watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int wl [10] = '{1, 5, 31, 32, 33, 40, 63, 64, 65, 0};
    logic [31:0] ml [4] = '{32'hFFFFFFFF, 32'hA5C30F81, 32'h80000001, 32'h0};
    logic [3:0] rl [8] = '{4'h3, 4'hC, 4'hF, 4'h0, 4'h6, 4'hA, 4'h8, 4'hE};
    int rc, ya;
    repeat (3) @(negedge clk);
    check(busy == 0, "R10 reset busy", busy, 0);
    check(mem_req == 0, "R10 reset mem_req", mem_req, 0);
    rst_n = 1;
    @(negedge clk);

    // R1: plain size write must not launch
    rc = req_cnt;
    wreg(3'd1, {16'd8, 16'd2});
    repeat (5) @(negedge clk);
    check(busy == 0, "R1 size write busy", busy, 0);
    check(req_cnt == rc, "R1 size write accesses", req_cnt - rc, 0);

    for (int i = 0; i < 20; i++)
      fill(i % 4 != 3, 40 + (i * 13) % 60, 3 + i * 5, wl[i % 10], 1 + i % 3, ml[i % 4],
           8'(8'hC3 + i * 17), 8'(8'h1E + i * 29),
           {i >= 10, i % 3 == 1, rl[i % 8]}, (i % 5 == 4) ? 8'h3C : 8'hFF);

    // R9 zero height then R8 stacking below unchanged Y
    fill(1, 200, 150, 7, 0, 32'hFFFFFFFF, 8'h44, 8'h00, 6'h03, 8'hFF);
    fill(0, 0, 0, 6, 2, 32'hF0F0F0F0, 8'h99, 8'h66, 6'h23, 8'hFF);
    fill(1, 200, 170, 0, 3, 32'hFFFFFFFF, 8'h44, 8'h00, 6'h03, 8'hFF);
    fill(0, 0, 0, 4, 1, 32'hFFFFFFFF, 8'h12, 8'h00, 6'h03, 8'hFF);

    // R10: writes during busy wait for next fill, start while busy ignored
    cur_x = 300; cur_y = 10;
    wreg(3'd0, {16'd300, 16'd10}); wreg(3'd3, 32'hFFFFFFFF); wreg(3'd4, 32'h11);
    wreg(3'd5, 32'h22); wreg(3'd6, 32'h23); wreg(3'd7, 32'hFF);
    wreg(3'd2, {16'd40, 16'd3});
    wreg(3'd3, 32'hF0000000); wreg(3'd4, 32'h77);
    wreg(3'd2, {16'd3, 16'd1});
    check(busy == 1, "R10 still busy", busy, 1);
    wait_idle();
    model(300, 10, 40, 3, 32'hFFFFFFFF, 8'h11, 8'h22, 6'h23, 8'hFF);
    compare(300, 10, 40, 3, 1, "R10 first fill unaffected");
    ya = 13;
    rc = req_cnt;
    repeat (4) @(negedge clk);
    check(req_cnt == rc && busy == 0, "R10 start while busy ignored", req_cnt - rc, 0);
    wreg(3'd2, {16'd6, 16'd1});
    wait_idle();
    model(300, ya, 6, 1, 32'hF0000000, 8'h77, 8'h22, 6'h23, 8'hFF);
    compare(300, ya, 6, 1, 1, "R10 R8 next fill uses new settings");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule